// File: doc/BRIEF.md
# Pipelined Fixed-Point Vector Rotator

This block rotates a signed two-dimensional fixed-point vector by a phase angle. It needs no multiplier in the rotation path. A new sample (X, Y, phase) can enter on every cycle in which the clock enable is high. Each sample first passes through a coarse quarter-turn fold, which swaps and negates the coordinates. It then passes through a chain of registered shift-add micro-rotations that drive the leftover angle toward zero. After that, the result is reduced to a narrower width with a rounding bias. A last stage scales it by a fixed constant that cancels the amplitude growth of the shift-add chain, and clamps it to the signed output range.

The phase word is unsigned, and its full scale is one turn, so adding 1 to the most significant bit means half a turn. Internally the coordinates get sign extension and a few fraction bits of working width, so the micro-rotation chain never overflows. A valid flag moves with the data through the same enabled registers. A caller can therefore match each output to its input without counting cycles, and it can pause the whole pipeline by dropping the enable.

Top module: `vec_rotator`

## Requirements
- R1: With default parameters, `out_valid` goes high exactly 17 enabled clock cycles after the cycle in which `in_valid` was sampled high. Only cycles with `ce` high count toward that latency.
- R2: While `ce` is low, no pipeline register changes, so `out_valid`, `out_x` and `out_y` hold their values.
- R3: Reset is synchronous. The edge at which `rst` is high clears `out_valid`, `out_x` and `out_y` to zero, and it drops every sample in flight, so none of them later appears as valid.
- R4: Phases of exactly 0, 0x4000, 0x8000 and 0xC000 (0°, 90°, 180°, 270°) give the input rotated by that quarter turn counter-clockwise, to within the tolerance of R5.
- R5: For any phase p, the output equals (x·cos θ − y·sin θ, x·sin θ + y·cos θ) to within 8 LSB per coordinate, where θ = 2π·p/65536. Positive angles rotate counter-clockwise.
- R6: When the ideal rotated coordinate is above 32767 or below −32768, the output is clamped to 32767 or −32768 respectively. For example, (32767, 32767) rotated by 0x2000 gives Y = 32767.
- R7: Phases just below a full turn (for example 0xFFFF) and phases between 180° and 360° are treated as small or negative angles, so the phase word wraps cleanly at one turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; all registers advance only when high |
| in_valid | input | 1 | Marks the sample on the inputs as valid |
| in_x | input | 16 | Signed input X coordinate |
| in_y | input | 16 | Signed input Y coordinate |
| in_phase | input | 16 | Unsigned rotation angle, one turn = 65536 |
| out_valid | output | 1 | Marks the output sample as valid |
| out_x | output | 16 | Signed rotated X coordinate |
| out_y | output | 16 | Signed rotated Y coordinate |

## Verification
The hardest case to reach from the ports is a pipeline stalled part-way through. Here the enable is dropped with one sample spread across the internal stages, and the latency must count only the enabled cycles. The bench drives this directly. It loads one vector and then sets the enable low on every other cycle until the result appears. It checks that the outputs stay unchanged in each stalled cycle, and that the valid pulse lands after exactly 17 enabled edges. Saturation is reached by feeding full-scale diagonal vectors at ±45°, which push one coordinate to about √2 of full scale.

// File: rtl/vec_rotator_pkg.sv
package vec_rotator_pkg;

   // number of arctangent entries available for the micro-rotation chain
   localparam int ATAN_DEPTH = 14;

   // quarter-turn selection made by the coarse fold
   typedef enum logic [1:0] {
      QTR_0   = 2'd0,
      QTR_90  = 2'd1,
      QTR_180 = 2'd2,
      QTR_270 = 2'd3
   } qtr_e;

   // arctangent of 2^-idx expressed in 1/65536 of a turn
   function automatic int unsigned atan_turn16(input int idx);
      case (idx)
         0:       return 8192;
         1:       return 4836;
         2:       return 2555;
         3:       return 1297;
         4:       return 651;
         5:       return 326;
         6:       return 163;
         7:       return 81;
         8:       return 41;
         9:       return 20;
         10:      return 10;
         11:      return 5;
         12:      return 3;
         13:      return 1;
         default: return 0;
      endcase
   endfunction

   // same constant rescaled to a phase word of pw bits (pw >= 16)
   function automatic longint unsigned atan_scaled(input int idx, input int pw);
      return longint'(atan_turn16(idx)) << (pw - 16);
   endfunction

endpackage

// File: rtl/vec_rot_fold.sv
module vec_rot_fold
   import vec_rotator_pkg::*;
#(
   parameter int IW   = 16,
   parameter int WW   = 20,
   parameter int PW   = 16,
   parameter int FRAC = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ce,
   input  logic                 v_i,
   input  logic signed [IW-1:0] x_i,
   input  logic signed [IW-1:0] y_i,
   input  logic        [PW-1:0] ph_i,
   output logic                 v_o,
   output logic signed [WW-1:0] x_o,
   output logic signed [WW-1:0] y_o,
   output logic signed [PW-1:0] z_o
);

   localparam logic [PW-1:0] EIGHTH = PW'(1) << (PW - 3);
   localparam logic signed [PW-1:0] RES_HI = PW'(1) << (PW - 3);

   logic signed [WW-1:0] xw, yw;
   logic        [PW-1:0] ph_off;
   qtr_e                 qtr;
   logic        [PW-1:0] ph_base;
   logic signed [WW-1:0] xn, yn;

   always_comb begin
      xw      = WW'(x_i) <<< FRAC;
      yw      = WW'(y_i) <<< FRAC;
      ph_off  = ph_i + EIGHTH;
      qtr     = qtr_e'(ph_off[PW-1 -: 2]);
      ph_base = {ph_off[PW-1 -: 2], {(PW-2){1'b0}}};
      unique case (qtr)
         QTR_0:   begin xn =  xw; yn =  yw; end
         QTR_90:  begin xn = -yw; yn =  xw; end
         QTR_180: begin xn = -xw; yn = -yw; end
         default: begin xn =  yw; yn = -xw; end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_o <= 1'b0;
         x_o <= '0;
         y_o <= '0;
         z_o <= '0;
      end else if (ce) begin
         v_o <= v_i;
         x_o <= xn;
         y_o <= yn;
         z_o <= $signed(ph_i - ph_base);
      end
   end

   // leftover angle after the fold stays within +/- one eighth turn
   p_residual_bound_r4: assert property (@(posedge clk) disable iff (rst)
      ce |=> (z_o <= RES_HI) && (z_o >= -RES_HI));

   // a stalled fold holds its registers
   p_fold_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(x_o) && $stable(y_o) && $stable(z_o) && $stable(v_o));

endmodule

// File: rtl/vec_rot_step.sv
module vec_rot_step
   import vec_rotator_pkg::*;
#(
   parameter int WW  = 20,
   parameter int PW  = 16,
   parameter int IDX = 0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ce,
   input  logic                 v_i,
   input  logic signed [WW-1:0] x_i,
   input  logic signed [WW-1:0] y_i,
   input  logic signed [PW-1:0] z_i,
   output logic                 v_o,
   output logic signed [WW-1:0] x_o,
   output logic signed [WW-1:0] y_o,
   output logic signed [PW-1:0] z_o
);

   localparam logic signed [PW-1:0] ANG = PW'(atan_scaled(IDX, PW));

   logic                 ccw;
   logic signed [WW-1:0] xs, ys;

   always_comb begin
      ccw = ~z_i[PW-1];
      xs  = x_i >>> IDX;
      ys  = y_i >>> IDX;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_o <= 1'b0;
         x_o <= '0;
         y_o <= '0;
         z_o <= '0;
      end else if (ce) begin
         v_o <= v_i;
         if (ccw) begin
            x_o <= x_i - ys;
            y_o <= y_i + xs;
            z_o <= z_i - ANG;
         end else begin
            x_o <= x_i + ys;
            y_o <= y_i - xs;
            z_o <= z_i + ANG;
         end
      end
   end

   // the residual moves toward zero: its sign decides the direction of the step
   p_step_direction_r5: assert property (@(posedge clk) disable iff (rst)
      (ce && !z_i[PW-1]) |=> (z_o < $past(z_i)));

   p_step_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(x_o) && $stable(y_o) && $stable(v_o));

endmodule

// File: rtl/vec_rot_round.sv
module vec_rot_round #(
   parameter int WW         = 20,
   parameter int FRAC       = 2,
   parameter int RW         = WW - FRAC + 1,
   parameter bit CONVERGENT = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ce,
   input  logic                 v_i,
   input  logic signed [WW-1:0] x_i,
   input  logic signed [WW-1:0] y_i,
   output logic                 v_o,
   output logic signed [RW-1:0] x_o,
   output logic signed [RW-1:0] y_o
);

   localparam int SW = WW + 1;
   localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC - 1);

   if (FRAC < 1) begin : g_bad_frac
      $error("vec_rot_round: FRAC must be at least 1");
   end
   if (RW != SW - FRAC) begin : g_bad_rw
      $error("vec_rot_round: RW must equal WW + 1 - FRAC");
   end

   logic signed [SW-1:0] xe, ye, bx, by, xb, yb;

   always_comb begin
      xe = SW'(x_i);
      ye = SW'(y_i);
   end

   if (CONVERGENT) begin : g_even
      always_comb begin
         bx = HALF - SW'(1) + SW'(x_i[FRAC]);
         by = HALF - SW'(1) + SW'(y_i[FRAC]);
      end
   end else begin : g_half_up
      always_comb begin
         bx = HALF;
         by = HALF;
      end
   end

   always_comb begin
      xb = xe + bx;
      yb = ye + by;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_o <= 1'b0;
         x_o <= '0;
         y_o <= '0;
      end else if (ce) begin
         v_o <= v_i;
         x_o <= xb[SW-1:FRAC];
         y_o <= yb[SW-1:FRAC];
      end
   end

   // rounded value lies within half an output LSB of the working value
   p_round_near_r5: assert property (@(posedge clk) disable iff (rst)
      ce |=> ((SW + 1)'(x_o) * (2 ** FRAC) - (SW + 1)'($past(x_i)) <= (SW + 1)'(HALF))
          && ((SW + 1)'($past(x_i)) - (SW + 1)'(x_o) * (2 ** FRAC) <= (SW + 1)'(HALF)));

endmodule

// File: rtl/vec_rot_scale.sv
module vec_rot_scale #(
   parameter int          RW   = 19,
   parameter int          OW   = 16,
   parameter int          GW   = 16,
   parameter int unsigned GAIN = 39797
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ce,
   input  logic                 v_i,
   input  logic signed [RW-1:0] x_i,
   input  logic signed [RW-1:0] y_i,
   output logic                 v_o,
   output logic signed [OW-1:0] x_o,
   output logic signed [OW-1:0] y_o
);

   localparam int PRW = RW + GW + 1;
   localparam logic signed [PRW-1:0] OMAX = PRW'((64'sd1 <<< (OW - 1)) - 1);
   localparam logic signed [PRW-1:0] OMIN = -PRW'(64'sd1 <<< (OW - 1));
   localparam logic signed [GW:0]    KG   = {1'b0, GW'(GAIN)};

   if (GAIN >= (64'd1 << GW)) begin : g_bad_gain
      $error("vec_rot_scale: GAIN must be a fraction below one");
   end

   logic signed [PRW-1:0] px, py, sx, sy;
   logic signed [OW-1:0]  cx, cy;

   function automatic logic signed [OW-1:0] clamp(input logic signed [PRW-1:0] v);
      if (v > OMAX)      return OW'(OMAX);
      else if (v < OMIN) return OW'(OMIN);
      else               return v[OW-1:0];
   endfunction

   always_comb begin
      px = PRW'(x_i) * PRW'(KG);
      py = PRW'(y_i) * PRW'(KG);
      sx = px >>> GW;
      sy = py >>> GW;
      cx = clamp(sx);
      cy = clamp(sy);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_o <= 1'b0;
         x_o <= '0;
         y_o <= '0;
      end else if (ce) begin
         v_o <= v_i;
         x_o <= cx;
         y_o <= cy;
      end
   end

   p_clamp_high_r6: assert property (@(posedge clk) disable iff (rst)
      (ce && sy > OMAX) |=> (y_o == OW'(OMAX)));

   p_clamp_low_r6: assert property (@(posedge clk) disable iff (rst)
      (ce && sy < OMIN) |=> (y_o == OW'(OMIN)));

   p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(x_o) && $stable(y_o) && $stable(v_o));

   p_reset_clear_r3: assert property (@(posedge clk)
      rst |=> !v_o && (x_o == '0) && (y_o == '0));

endmodule

// File: rtl/vec_rotator.sv
module vec_rotator
   import vec_rotator_pkg::*;
#(
   parameter int          IW         = 16,
   parameter int          WW         = 20,
   parameter int          PW         = 16,
   parameter int          STEPS      = 14,
   parameter int          GW         = 16,
   parameter int unsigned GAIN       = 39797,
   parameter bit          CONVERGENT = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ce,
   input  logic                 in_valid,
   input  logic signed [IW-1:0] in_x,
   input  logic signed [IW-1:0] in_y,
   input  logic        [PW-1:0] in_phase,
   output logic                 out_valid,
   output logic signed [IW-1:0] out_x,
   output logic signed [IW-1:0] out_y
);

   localparam int FRAC    = WW - IW - 2;
   localparam int RW      = WW - FRAC + 1;
   localparam int LATENCY = STEPS + 3;

   if (FRAC < 1) begin : g_bad_ww
      $error("vec_rotator: WW must exceed IW by at least 3");
   end
   if (STEPS < 1 || STEPS > ATAN_DEPTH) begin : g_bad_steps
      $error("vec_rotator: STEPS outside arctangent table");
   end
   if (PW < 16) begin : g_bad_pw
      $error("vec_rotator: PW must be at least 16");
   end
   if (LATENCY != STEPS + 3) begin : g_bad_lat
      $error("vec_rotator: latency bookkeeping mismatch");
   end

   logic                 sv [0:STEPS];
   logic signed [WW-1:0] sx [0:STEPS];
   logic signed [WW-1:0] sy [0:STEPS];
   logic signed [PW-1:0] sz [0:STEPS];

   vec_rot_fold #(.IW(IW), .WW(WW), .PW(PW), .FRAC(FRAC)) u_fold (
      .clk (clk), .rst (rst), .ce (ce),
      .v_i (in_valid), .x_i (in_x), .y_i (in_y), .ph_i (in_phase),
      .v_o (sv[0]), .x_o (sx[0]), .y_o (sy[0]), .z_o (sz[0])
   );

   for (genvar i = 0; i < STEPS; i++) begin : g_step
      vec_rot_step #(.WW(WW), .PW(PW), .IDX(i)) u_step (
         .clk (clk), .rst (rst), .ce (ce),
         .v_i (sv[i]),   .x_i (sx[i]),   .y_i (sy[i]),   .z_i (sz[i]),
         .v_o (sv[i+1]), .x_o (sx[i+1]), .y_o (sy[i+1]), .z_o (sz[i+1])
      );
   end

   logic                 rv;
   logic signed [RW-1:0] rx, ry;
   logic signed [PW-1:0] z_last;

   assign z_last = sz[STEPS];

   vec_rot_round #(.WW(WW), .FRAC(FRAC), .RW(RW), .CONVERGENT(CONVERGENT)) u_round (
      .clk (clk), .rst (rst), .ce (ce),
      .v_i (sv[STEPS]), .x_i (sx[STEPS]), .y_i (sy[STEPS]),
      .v_o (rv), .x_o (rx), .y_o (ry)
   );

   vec_rot_scale #(.RW(RW), .OW(IW), .GW(GW), .GAIN(GAIN)) u_scale (
      .clk (clk), .rst (rst), .ce (ce),
      .v_i (rv), .x_i (rx), .y_i (ry),
      .v_o (out_valid), .x_o (out_x), .y_o (out_y)
   );

   // after the full chain the leftover angle is within a few LSB of zero
   p_residual_converged_r5: assert property (@(posedge clk) disable iff (rst)
      (ce && sv[STEPS-1]) |=> (z_last <= PW'(2 ** (PW - 14))) && (z_last >= -PW'(2 ** (PW - 14))));

endmodule

// File: tb/vec_rotator_test.sv
module vec_rotator_test;

   localparam int NV  = 13;
   localparam int LAT = 17;
   localparam int TOL = 8;
   localparam real TWO_PI = 6.283185307179586;

   // table of vectors: x, y, phase
   localparam int TX [NV] = '{10000, 10000, 10000, 10000, 12000, -9000, 20000, -32768,
                               0, 32767, -32768, 32767, 5000};
   localparam int TY [NV] = '{0, 0, 0, 0, 3000, 7000, -15000, 0,
                               12345, 32767, -32768, -32767, -5000};
   localparam int TP [NV] = '{16'h0000, 16'h4000, 16'h8000, 16'hC000, 16'h1555, 16'hD555,
                               16'h2AAA, 16'h1000, 16'hFFFF, 16'h2000, 16'h2000, 16'hE000,
                               16'h9ABC};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ce = 1'b0;
   logic in_valid = 1'b0;
   logic signed [15:0] in_x = '0;
   logic signed [15:0] in_y = '0;
   logic [15:0] in_phase = '0;
   logic out_valid;
   logic signed [15:0] out_x, out_y;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   vec_rotator uut (
      .clk (clk), .rst (rst), .ce (ce), .in_valid (in_valid),
      .in_x (in_x), .in_y (in_y), .in_phase (in_phase),
      .out_valid (out_valid), .out_x (out_x), .out_y (out_y)
   );

   function automatic int clamp16(input real v);
      int r;
      if (v > 32767.0)  return 32767;
      if (v < -32768.0) return -32768;
      r = int'(v);
      return r;
   endfunction

   function automatic int exp_x(input int x, input int y, input int p);
      real th = TWO_PI * real'(p) / 65536.0;
      return clamp16(real'(x) * $cos(th) - real'(y) * $sin(th));
   endfunction

   function automatic int exp_y(input int x, input int y, input int p);
      real th = TWO_PI * real'(p) / 65536.0;
      return clamp16(real'(x) * $sin(th) + real'(y) * $cos(th));
   endfunction

   function automatic bit near(input int a, input int b);
      return (a - b <= TOL) && (b - a <= TOL);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int ax, input int ay, input int ex, input int ey);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual (%0d,%0d) expected (%0d,%0d)", req, what, ax, ay, ex, ey);
      end
   endtask

   function automatic string req_of(input int i);
      if (i >= 9 && i <= 11) return "R6";
      if (i <= 3)            return "R4";
      if (i == 8 || i == 5 || i == 11) return "R7";
      return "R5";
   endfunction

   task automatic load(input int x, input int y, input int p);
      @(negedge clk);
      in_x     = 16'(x);
      in_y     = 16'(y);
      in_phase = 16'(p);
      in_valid = 1'b1;
      ce       = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      int ex, ey;
      bit pre;
      bit seen;
      int sx, sy;
      bit stable_ok;
      int enabled;

      // R3: reset state
      repeat (3) @(negedge clk);
      check(!out_valid && out_x == 0 && out_y == 0, "R3", "reset state",
            out_x, out_y, 0, 0);
      rst = 1'b0;
      ce  = 1'b1;
      repeat (2) @(negedge clk);

      // vector table walk (R1, R4, R5, R6, R7)
      for (int i = 0; i < NV; i++) begin
         load(TX[i], TY[i], TP[i]);
         repeat (LAT - 2) @(negedge clk);
         pre = out_valid;
         @(negedge clk);
         ex = exp_x(TX[i], TY[i], TP[i]);
         ey = exp_y(TX[i], TY[i], TP[i]);
         check(!pre && out_valid, "R1", "valid timing", int'(pre), int'(out_valid), 0, 1);
         check(near(out_x, ex) && near(out_y, ey), req_of(i), "rotation",
               out_x, out_y, ex, ey);
         if (i == 9)
            check(out_y == 32767, "R6", "clamp high exact", out_x, out_y, ex, 32767);
         if (i == 10)
            check(out_y == -32768, "R6", "clamp low exact", out_x, out_y, ex, -32768);
         @(negedge clk);
      end

      // R2 and R1: stall every other cycle while a sample is in flight
      load(TX[4], TY[4], TP[4]);
      enabled   = 1;
      stable_ok = 1'b1;
      seen      = 1'b0;
      while (enabled < LAT) begin
         ce = 1'b0;
         sx = out_x;
         sy = out_y;
         pre = out_valid;
         @(negedge clk);
         if (out_x != sx || out_y != sy || out_valid != pre) stable_ok = 1'b0;
         if (out_valid) seen = 1'b1;
         ce = 1'b1;
         @(negedge clk);
         enabled++;
         if (out_valid && enabled < LAT) seen = 1'b1;
      end
      check(stable_ok, "R2", "outputs frozen while ce low", out_x, out_y, sx, sy);
      ex = exp_x(TX[4], TY[4], TP[4]);
      ey = exp_y(TX[4], TY[4], TP[4]);
      check(!seen && out_valid, "R1", "latency counts enabled cycles only",
            int'(seen), int'(out_valid), 0, 1);
      check(near(out_x, ex) && near(out_y, ey), "R2", "stalled result intact",
            out_x, out_y, ex, ey);

      // R3: reset drops samples in flight
      load(TX[6], TY[6], TP[6]);
      repeat (5) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(!out_valid && out_x == 0 && out_y == 0, "R3", "cleared by reset",
            out_x, out_y, 0, 0);
      rst  = 1'b0;
      seen = 1'b0;
      repeat (LAT + 4) begin
         @(negedge clk);
         if (out_valid) seen = 1'b1;
      end
      check(!seen, "R3", "flushed sample never valid", int'(seen), 0, 0, 0);

      // R5: back-to-back samples, one per cycle
      @(negedge clk);
      for (int i = 4; i < 8; i++) begin
         in_x = 16'(TX[i]); in_y = 16'(TY[i]); in_phase = 16'(TP[i]); in_valid = 1'b1;
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (LAT - 4) @(negedge clk);
      for (int i = 4; i < 8; i++) begin
         ex = exp_x(TX[i], TY[i], TP[i]);
         ey = exp_y(TX[i], TY[i], TP[i]);
         check(out_valid && near(out_x, ex) && near(out_y, ey), "R5", "streamed sample",
               out_x, out_y, ex, ey);
         @(negedge clk);
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule